// File: doc/BRIEF.md
# Multi-Source Reset Controller

The block merges six reset requests into three internal reset lines: a master line, a clock-domain line and a line that reaches the external pin. The sources are the reset pin, power-up detection, watchdog timeout, an internal halt (for example a double bus fault), loss of the clock reference, and entry into test mode. Every request first passes a two-stage synchronizer. Power-up, watchdog and halt requests then assert reset right away. Pin, clock-loss and test requests are held pending until the bus reports that no cycle is in flight, so an internal byte or aligned-word write in progress is allowed to complete.

Once reset is asserted, it stays asserted while any request is active and for a fixed stretch of cycles after the last request clears. On the final stretch cycle the controller captures configuration from the data bus, the clock-mode pin and the breakpoint pin. A one-hot cause register records which source started the most recent reset.

The controller has four states. `ST_IDLE` goes to `ST_ASSERT` on an async request, or to `ST_WAIT_BUS` on a sync request. `ST_WAIT_BUS` goes to `ST_ASSERT` when the bus is idle or an async request appears. `ST_ASSERT` goes to `ST_STRETCH` when no request is active. `ST_STRETCH` goes back to `ST_ASSERT` on any request, and to `ST_IDLE` after the stretch ends, which is also when the mode latch captures.

Top module: `rstctl_top`

## Requirements
- R1: An asynchronous request (power-up, watchdog, halt) that is high at a clock edge drives rst_master high after the third edge counted from that edge, whatever the value of bus_idle.
- R2: A synchronous request (pin, clock loss, test) first moves the controller to the wait state. Reset asserts on the edge after which bus_idle is sampled high in the wait state, or earlier if an async request arrives. A sync request that drops while waiting stays pending.
- R3: rst_clock is asserted only when some source other than test mode has been active during the current reset. A reset caused by test mode alone keeps rst_clock low.
- R4: rst_extern always equals rst_master, and rst_clock is never high while rst_master is low.
- R5: After the last synchronized request clears, the reset lines stay high for exactly 16 more cycles (STRETCH_CYC).
- R6: On entry to reset, rst_cause takes a one-hot value naming a single source. The bit positions are ext=0, pwr=1, wdog=2, halt=3, clkloss=4, test=5. The priority order is pwr, wdog, halt, clkloss, ext, test.
- R7: rst_cause holds its value from one reset entry to the next, and it is zero after controller reset.
- R8: cfg_word captures data_in on the last stretch cycle and is otherwise stable. Its reset value is all ones, and bit 0 low selects the alternate (8-bit) boot port width.
- R9: sysclk_vco captures modclk_pin at the same edge (high selects the VCO, low the external clock). Its reset value is 1.
- R10: bdm_enable captures the inverse of bkpt_pin at that edge. Its reset value is 0.
- R11: rsv_mode captures the inverse of data_in bit 11 at that edge, flagging the reserved mode.
- R12: A request arriving during the stretch returns the controller to ST_ASSERT, and the full stretch restarts once the request clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low initialisation of the controller itself |
| req_ext | input | 1 | Reset pin request (sync) |
| req_pwr | input | 1 | Power-up detect request (async) |
| req_wdog | input | 1 | Watchdog timeout request (async) |
| req_halt | input | 1 | Internal halt request (async) |
| req_clkloss | input | 1 | Clock reference lost request (sync) |
| req_test | input | 1 | Test-mode entry request (sync) |
| bus_idle | input | 1 | High when no bus cycle is in progress |
| data_in | input | DATA_W | Data bus sampled for configuration |
| modclk_pin | input | 1 | Clock-mode pin |
| bkpt_pin | input | 1 | Breakpoint pin |
| rst_master | output | 1 | Master reset line |
| rst_clock | output | 1 | Clock-domain reset line |
| rst_extern | output | 1 | External reset line |
| rst_cause | output | 6 | One-hot cause of the last reset |
| cfg_word | output | DATA_W | Latched configuration word |
| sysclk_vco | output | 1 | 1 = VCO is system clock |
| bdm_enable | output | 1 | Background debug enabled |
| rsv_mode | output | 1 | Reserved mode was selected |

## Verification
The assertions assume that the requests are quiet while rst_n is low. The async-latency property also counts its window from the third edge after release, so samples taken during controller reset are never used. bus_idle is taken to be a synchronous signal, and the sync-path property relies on it being valid at the entry edge. The stimulus changes every input only at falling edges and lowers all requests before releasing rst_n. It runs each source alone, mixes sources together, and holds bus_idle low for long waits.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int NSRC    = 6;
    localparam int SRC_EXT = 0;
    localparam int SRC_PWR = 1;
    localparam int SRC_WDG = 2;
    localparam int SRC_HLT = 3;
    localparam int SRC_CLK = 4;
    localparam int SRC_TST = 5;

    // Sources that must wait for a bus-cycle boundary
    localparam logic [NSRC-1:0] SYNC_MASK    = 6'b110001;
    localparam logic [NSRC-1:0] ASYNC_MASK   = ~SYNC_MASK;
    // Sources that also drive the clock-domain reset line
    localparam logic [NSRC-1:0] CLKLINE_MASK = 6'b011111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_ASSERT,
        ST_STRETCH
    } rst_state_e;

    // Reduce a set of active sources to one cause bit by fixed priority
    function automatic logic [NSRC-1:0] pick_cause(input logic [NSRC-1:0] v);
        logic [NSRC-1:0] r;
        r = '0;
        if      (v[SRC_PWR]) r[SRC_PWR] = 1'b1;
        else if (v[SRC_WDG]) r[SRC_WDG] = 1'b1;
        else if (v[SRC_HLT]) r[SRC_HLT] = 1'b1;
        else if (v[SRC_CLK]) r[SRC_CLK] = 1'b1;
        else if (v[SRC_EXT]) r[SRC_EXT] = 1'b1;
        else if (v[SRC_TST]) r[SRC_TST] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rstctl_fsm.sv
module rstctl_fsm
    import rstctl_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_s,
    input  logic            bus_idle,
    output logic            line_master,
    output logic            line_clock,
    output logic [NSRC-1:0] cause,
    output logic            latch_now
);
    localparam int CW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    rst_state_e      state, nxt;
    logic [CW-1:0]   cnt;
    logic [NSRC-1:0] pend;
    logic            clk_line;
    logic            any_req, any_async, any_sync, enter;
    logic [NSRC-1:0] cause_vec;

    assign any_req   = |req_s;
    assign any_async = |(req_s & ASYNC_MASK);
    assign any_sync  = |(req_s & SYNC_MASK);
    assign cause_vec = req_s | pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (any_async)     nxt = ST_ASSERT;
                else if (any_sync) nxt = ST_WAIT_BUS;
            end
            ST_WAIT_BUS: begin
                if (any_async || bus_idle) nxt = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (!any_req) nxt = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (any_req)          nxt = ST_ASSERT;
                else if (cnt == LAST) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign enter = (state == ST_IDLE || state == ST_WAIT_BUS) && (nxt == ST_ASSERT);

    // Stretch counter, pending sync requests, clock-line membership, cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            pend     <= '0;
            clk_line <= 1'b0;
            cause    <= '0;
        end else begin
            if (state != ST_STRETCH) cnt <= '0;
            else if (cnt != LAST)    cnt <= cnt + 1'b1;

            unique case (state)
                ST_IDLE:     pend <= req_s & SYNC_MASK;
                ST_WAIT_BUS: pend <= pend | (req_s & SYNC_MASK);
                default:     pend <= '0;
            endcase

            if (enter) begin
                cause    <= pick_cause(cause_vec);
                clk_line <= |(cause_vec & CLKLINE_MASK);
            end else if (state == ST_ASSERT || state == ST_STRETCH) begin
                clk_line <= clk_line | (|(req_s & CLKLINE_MASK));
            end
        end
    end

    // Outputs
    always_comb begin
        line_master = 1'b0;
        line_clock  = 1'b0;
        latch_now   = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT_BUS: ;
            ST_ASSERT: begin
                line_master = 1'b1;
                line_clock  = clk_line;
            end
            ST_STRETCH: begin
                line_master = 1'b1;
                line_clock  = clk_line;
                latch_now   = (cnt == LAST) && !any_req;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rstctl_mode_latch.sv
module rstctl_mode_latch #(
    parameter int DATA_W  = 16,
    parameter int RSV_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_now,
    input  logic [DATA_W-1:0] data_in,
    input  logic              modclk_pin,
    input  logic              bkpt_pin,
    output logic [DATA_W-1:0] cfg_word,
    output logic              sysclk_vco,
    output logic              bdm_enable,
    output logic              rsv_mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word   <= '1;
            sysclk_vco <= 1'b1;
            bdm_enable <= 1'b0;
            rsv_mode   <= 1'b0;
        end else if (latch_now) begin
            cfg_word   <= data_in;
            sysclk_vco <= modclk_pin;
            bdm_enable <= ~bkpt_pin;
            rsv_mode   <= ~data_in[RSV_BIT];
        end
    end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int RSV_BIT     = 11,
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_ext,
    input  logic              req_pwr,
    input  logic              req_wdog,
    input  logic              req_halt,
    input  logic              req_clkloss,
    input  logic              req_test,
    input  logic              bus_idle,
    input  logic [DATA_W-1:0] data_in,
    input  logic              modclk_pin,
    input  logic              bkpt_pin,
    output logic              rst_master,
    output logic              rst_clock,
    output logic              rst_extern,
    output logic [5:0]        rst_cause,
    output logic [DATA_W-1:0] cfg_word,
    output logic              sysclk_vco,
    output logic              bdm_enable,
    output logic              rsv_mode
);
    logic [NSRC-1:0] req_raw, req_s;
    logic            line_master, line_clock, latch_now;

    always_comb begin
        req_raw          = '0;
        req_raw[SRC_EXT] = req_ext;
        req_raw[SRC_PWR] = req_pwr;
        req_raw[SRC_WDG] = req_wdog;
        req_raw[SRC_HLT] = req_halt;
        req_raw[SRC_CLK] = req_clkloss;
        req_raw[SRC_TST] = req_test;
    end

    rstctl_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
    );

    rstctl_fsm #(.STRETCH_CYC(STRETCH_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .bus_idle(bus_idle),
        .line_master(line_master), .line_clock(line_clock),
        .cause(rst_cause), .latch_now(latch_now)
    );

    rstctl_mode_latch #(.DATA_W(DATA_W), .RSV_BIT(RSV_BIT)) u_mode (
        .clk(clk), .rst_n(rst_n), .latch_now(latch_now), .data_in(data_in),
        .modclk_pin(modclk_pin), .bkpt_pin(bkpt_pin), .cfg_word(cfg_word),
        .sysclk_vco(sysclk_vco), .bdm_enable(bdm_enable), .rsv_mode(rsv_mode)
    );

    assign rst_master = line_master;
    assign rst_extern = line_master;
    assign rst_clock  = line_clock;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_pwr,
    input logic              req_wdog,
    input logic              req_halt,
    input logic              bus_idle,
    input logic              rst_master,
    input logic              rst_clock,
    input logic              rst_extern,
    input logic [5:0]        rst_cause,
    input logic [DATA_W-1:0] cfg_word
);
    logic [1:0] age;
    logic       async_any;
    assign async_any = req_pwr | req_wdog | req_halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 1'b1;
    end

    p_async_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(async_any, 3)) |-> rst_master);

    p_sync_waits_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_master) && age == 2'd3 && !$past(async_any, 3)) |-> $past(bus_idle));

    p_lines_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_extern == rst_master) && (!rst_clock || rst_master));

    p_cause_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rst_cause));

    p_cause_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_master |=> $stable(rst_cause));

    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_master |=> $stable(cfg_word));
endmodule

bind rstctl_top rstctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_pwr(req_pwr), .req_wdog(req_wdog),
    .req_halt(req_halt), .bus_idle(bus_idle), .rst_master(rst_master),
    .rst_clock(rst_clock), .rst_extern(rst_extern), .rst_cause(rst_cause),
    .cfg_word(cfg_word)
);

// File: tb/rstctl_top_bench.sv
module rstctl_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ext = 0, req_pwr = 0, req_wdog = 0, req_halt = 0;
    logic        req_clkloss = 0, req_test = 0, bus_idle = 0;
    logic [15:0] data_in = 16'hFFFF;
    logic        modclk_pin = 1, bkpt_pin = 1;
    logic        rst_master, rst_clock, rst_extern;
    logic [5:0]  rst_cause;
    logic [15:0] cfg_word;
    logic        sysclk_vco, bdm_enable, rsv_mode;

    int checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    rstctl_top u_rstctl_top (.*);

    // Behavioural reference model
    logic [5:0]  dq[$];
    int          phase;       // 0 idle, 1 waiting for bus, 2 on, 3 stretch
    int          cnt;
    logic [5:0]  m_pend, m_cause;
    bit          m_clk;
    logic [15:0] m_cfg;
    bit          m_vco, m_bdm, m_rsv;

    function automatic logic [5:0] prio(input logic [5:0] v);
        if (v[1]) return 6'b000010;
        if (v[2]) return 6'b000100;
        if (v[3]) return 6'b001000;
        if (v[4]) return 6'b010000;
        if (v[0]) return 6'b000001;
        if (v[5]) return 6'b100000;
        return 6'b0;
    endfunction

    task automatic model_reset();
        dq = {6'b0, 6'b0};
        phase = 0; cnt = 0; m_pend = 0; m_cause = 0; m_clk = 0;
        m_cfg = 16'hFFFF; m_vco = 1; m_bdm = 0; m_rsv = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            logic [5:0] s, c;
            bit a, y;
            s = dq.pop_front();
            dq.push_back({req_test, req_clkloss, req_halt, req_wdog, req_pwr, req_ext});
            a = (s[1] | s[2] | s[3]);
            y = (s[0] | s[4] | s[5]);
            if (phase == 0) begin
                if (a) begin phase = 2; m_cause = prio(s); m_clk = |s[4:0]; end
                else if (y) begin phase = 1; m_pend = s & 6'b110001; end
            end else if (phase == 1) begin
                c = s | m_pend;
                if (a || bus_idle) begin
                    phase = 2; m_cause = prio(c); m_clk = |c[4:0]; m_pend = 0;
                end else m_pend = c & 6'b110001;
            end else if (phase == 2) begin
                m_clk = m_clk | (|s[4:0]);
                if (s == 0) begin phase = 3; cnt = 0; end
            end else begin
                m_clk = m_clk | (|s[4:0]);
                if (s != 0) phase = 2;
                else if (cnt == 15) begin
                    phase = 0;
                    m_cfg = data_in; m_vco = modclk_pin;
                    m_bdm = ~bkpt_pin; m_rsv = ~data_in[11];
                end else cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge once out of reset
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            bit on;
            on = (phase >= 2);
            chk("R1 R2 R5 R12 rst_master", 16'(rst_master), 16'(on));
            chk("R4 rst_extern", 16'(rst_extern), 16'(on));
            chk("R3 rst_clock", 16'(rst_clock), 16'(on && m_clk));
            chk("R6 R7 rst_cause", 16'(rst_cause), 16'(m_cause));
            chk("R8 cfg_word", cfg_word, m_cfg);
            chk("R9 sysclk_vco", 16'(sysclk_vco), 16'(m_vco));
            chk("R10 bdm_enable", 16'(bdm_enable), 16'(m_bdm));
            chk("R11 rsv_mode", 16'(rsv_mode), 16'(m_rsv));
        end
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        idle(3);
        while (rst_master) @(negedge clk);
        idle(3);
    endtask

    initial begin
        idle(3);
        // Reset state: lines low, cause zero, modes at defaults (R7, R8, R9, R10)
        chk("R7 reset cause", 16'(rst_cause), 16'h0);
        chk("R8 reset cfg", cfg_word, 16'hFFFF);
        chk("R9 reset vco", 16'(sysclk_vco), 16'h1);
        chk("R10 reset bdm", 16'(bdm_enable), 16'h0);
        rst_n = 1'b1;
        idle(4);

        // R1: watchdog resets with the bus busy
        bus_idle = 0; req_wdog = 1; idle(3); req_wdog = 0;
        wait_quiet();

        // R2: pin reset waits for the bus; request drops while still pending
        req_ext = 1; idle(2); req_ext = 0; idle(12);
        chk("R2 held off by busy bus", 16'(rst_master), 16'h0);
        bus_idle = 1; wait_quiet();

        // R3, R8, R11, R10, R9: test-only reset with alternate pin levels
        data_in = 16'hF7FE; modclk_pin = 0; bkpt_pin = 0;
        req_test = 1; idle(4); req_test = 0;
        wait_quiet();
        chk("R11 reserved flagged", 16'(rsv_mode), 16'h1);
        chk("R8 byte boot width", 16'(cfg_word[0]), 16'h0);

        // R6: power-up and pin together, power-up wins
        data_in = 16'hFFFF; modclk_pin = 1; bkpt_pin = 1;
        req_pwr = 1; req_ext = 1; idle(5); req_pwr = 0; req_ext = 0;
        wait_quiet();
        chk("R6 power-up cause", 16'(rst_cause), 16'h0002);

        // R12: halt, then clock loss during the stretch restarts it
        req_halt = 1; idle(2); req_halt = 0; idle(10);
        req_clkloss = 1; idle(2); req_clkloss = 0;
        wait_quiet();

        // R3: test reset joined by halt brings in the clock line
        bus_idle = 1; req_test = 1; idle(6); req_halt = 1; idle(2);
        req_test = 0; req_halt = 0;
        wait_quiet();

        // R2: busy bus with async arrival during the wait
        bus_idle = 0; req_clkloss = 1; idle(6); req_wdog = 1; idle(2);
        req_clkloss = 0; req_wdog = 0;
        wait_quiet();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule